// File: doc/BRIEF.md
# Packed Fused Multiply-Add Operand Router and Mask Merge

This block sits in front of and behind a bank of external single-precision fused multiply-add lanes. It registers one vector operation per cycle: three 512-bit source vectors (the destination, which is also a source, a second source and a third source), an operand-ordering code, a length code, a per-lane write mask with its enable and zeroing control, a broadcast flag, a flag for a memory third source, a flag for the legacy encoding, and two candidate rounding modes. For every lane it presents the multiplicand (`lane_x`), the multiplier (`lane_y`) and the addend (`lane_z`) to the arithmetic lanes, which compute `x*y+z`. It also presents the rounding mode those lanes must use.

The lanes return their results and 5-bit exception flags a fixed `LAT` cycles after issue. A context pipeline of the same depth carries the destination vector and the per-lane write decisions alongside them. The merge stage then builds the final 512-bit destination. Written lanes take the lane result. Masked lanes keep the old destination value or become zero. Every lane beyond the active length is cleared. The flags of the written lanes are OR-reduced into one status field.

Top module: `fma_route_merge`

## Requirements
- R1: With `in_form` = 0, lane j receives x = dest_j, y = src3_j, z = src2_j.
- R2: With `in_form` = 1, lane j receives x = src2_j, y = dest_j, z = src3_j.
- R3: With `in_form` = 2, lane j receives x = src2_j, y = src3_j, z = dest_j.
- R4: Lane j occupies bits 32j+31..32j. `in_vlen` 0, 1 and 2 (and 3) make 4, 8 and 16 lanes active. Every output bit of an inactive lane, up to bit 511, is 0.
- R5: If `in_mask_en`=1, `in_legacy`=0, `in_zero_mode`=0 and mask bit j is 0, active output lane j equals dest_j unchanged.
- R6: If `in_mask_en`=1, `in_legacy`=0, `in_zero_mode`=1 and mask bit j is 0, active output lane j is 0. With masking disabled, every active lane is written with the lane result.
- R7: If `in_bcast`=1 and `in_src3_mem`=1, every lane uses src3 bits 31:0 as its third source. If `in_bcast`=1 and `in_src3_mem`=0, the third-source lanes are used as they are.
- R8: `lane_rc` equals `in_embed_rc` when the length is 512 bits, `in_bcast`=1, `in_src3_mem`=0 and `in_legacy`=0. Otherwise it equals `in_global_rc`.
- R9: With `in_legacy`=1, the mask, its enable and the zeroing control are ignored. A 512-bit length code acts as 256 bits (8 lanes). The rounding mode comes from `in_global_rc`.
- R10: After reset, `out_valid`, `lane_issue` and `out_data` are 0. `lane_issue` is high in the cycle after the edge that samples `in_valid`. `out_valid` rises `LAT`+1 edges after that edge. One operation may start every cycle, and results leave in order.
- R11: `out_flags` is the OR of the 5-bit `lane_flags` of written lanes only. Masked-off or inactive lanes contribute nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation present on the inputs |
| in_form | input | 2 | Operand ordering: 0, 1 or 2 |
| in_vlen | input | 2 | Length: 0=128, 1=256, 2/3=512 bits |
| in_dest | input | 512 | Destination vector, also a source |
| in_src2 | input | 512 | Second source vector |
| in_src3 | input | 512 | Third source vector |
| in_mask | input | 16 | Per-lane write mask |
| in_mask_en | input | 1 | Write mask in use |
| in_zero_mode | input | 1 | 1: masked lanes cleared, 0: kept |
| in_bcast | input | 1 | Broadcast / rounding-override bit |
| in_src3_mem | input | 1 | Third source came from memory |
| in_legacy | input | 1 | Legacy encoding (no mask, max 256 bits) |
| in_embed_rc | input | 2 | Rounding mode carried in the operation |
| in_global_rc | input | 2 | Rounding mode from the global control register |
| lane_issue | output | 1 | Operands valid for the lanes |
| lane_x | output | 512 | Multiplicand per lane |
| lane_y | output | 512 | Multiplier per lane |
| lane_z | output | 512 | Addend per lane |
| lane_enable | output | 16 | Lanes whose result will be written |
| lane_rc | output | 2 | Rounding mode for the lanes |
| lane_res | input | 512 | Lane results, LAT cycles after issue |
| lane_flags | input | 80 | 5 exception flags per lane, lane j at bits 5j+4..5j |
| out_valid | output | 1 | Merged result valid |
| out_data | output | 512 | Merged destination vector |
| out_flags | output | 5 | OR of written lanes' flags |

## Verification
A wrong form decode or a broadcast error puts the wrong value into a lane operand. The stand-in lanes compute a non-symmetric function, so it shows up in the merged data `LAT`+1 cycles after the request. A context pipeline that is out of step with the lanes pairs results with the wrong destination or the wrong mask. A wrong valid depth moves `out_valid` off its expected cycle. Both show at the very first result. A wrong rounding choice is visible on `lane_rc` one cycle after the request. Flag leaks from masked lanes appear in `out_flags` with the same result.

// File: rtl/fma_route_pkg.sv
package fma_route_pkg;

  localparam int ELEM_W = 32;
  localparam int RC_W   = 2;

  typedef logic [ELEM_W-1:0] elem_t;

  typedef struct packed {
    elem_t mul_x;
    elem_t mul_y;
    elem_t add_z;
  } trio_t;

  // Operand ordering per lane: x*y+z
  function automatic trio_t route_trio(logic [1:0] form, elem_t d, elem_t s2, elem_t s3);
    trio_t t;
    case (form)
      2'd1:    t = '{mul_x: s2, mul_y: d,  add_z: s3};
      2'd2:    t = '{mul_x: s2, mul_y: s3, add_z: d};
      default: t = '{mul_x: d,  mul_y: s3, add_z: s2};
    endcase
    return t;
  endfunction

  // Number of active lanes for a length code; legacy caps at 256 bits
  function automatic logic [7:0] lane_count(logic [1:0] vlen, logic legacy);
    case (vlen)
      2'd0:    return 8'd4;
      2'd1:    return 8'd8;
      default: return legacy ? 8'd8 : 8'd16;
    endcase
  endfunction

  function automatic elem_t merge_lane(logic wr, logic act, logic zero, elem_t res, elem_t d);
    if (!act)  return '0;
    if (wr)    return res;
    if (zero)  return '0;
    return d;
  endfunction

  function automatic logic [RC_W-1:0] pick_rc(logic [1:0] vlen, logic bc, logic mem, logic leg,
                                              logic [RC_W-1:0] erc, logic [RC_W-1:0] grc);
    return (vlen >= 2'd2 && bc && !mem && !leg) ? erc : grc;
  endfunction

endpackage

// File: rtl/fma_operand_route.sv
module fma_operand_route
  import fma_route_pkg::*;
#(
  parameter int LANES = 16,
  localparam int VW = LANES * ELEM_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld,
  input  logic [1:0]    form,
  input  logic          bcast_mem,
  input  logic [VW-1:0] dest,
  input  logic [VW-1:0] src2,
  input  logic [VW-1:0] src3,
  output logic [VW-1:0] op_x,
  output logic [VW-1:0] op_y,
  output logic [VW-1:0] op_z
);

  logic [VW-1:0] src3_eff;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    trio_t t;
    assign src3_eff[k*ELEM_W +: ELEM_W] = bcast_mem ? src3[ELEM_W-1:0] : src3[k*ELEM_W +: ELEM_W];
    assign t = route_trio(form, dest[k*ELEM_W +: ELEM_W], src2[k*ELEM_W +: ELEM_W],
                          src3_eff[k*ELEM_W +: ELEM_W]);
    assign op_x[k*ELEM_W +: ELEM_W] = t.mul_x;
    assign op_y[k*ELEM_W +: ELEM_W] = t.mul_y;
    assign op_z[k*ELEM_W +: ELEM_W] = t.add_z;

    // R1: form 0 takes the destination as multiplicand and src2 as addend
    p_form0_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
      vld && form == 2'd0 |-> op_x[k*ELEM_W +: ELEM_W] == dest[k*ELEM_W +: ELEM_W] &&
                              op_z[k*ELEM_W +: ELEM_W] == src2[k*ELEM_W +: ELEM_W]);
    // R3: form 2 takes the destination as addend
    p_form2_addend_r3: assert property (@(posedge clk) disable iff (!rst_n)
      vld && form == 2'd2 |-> op_z[k*ELEM_W +: ELEM_W] == dest[k*ELEM_W +: ELEM_W]);
    // R7: broadcast from memory feeds lane 0 of src3 everywhere
    p_bcast_lane0_r7: assert property (@(posedge clk) disable iff (!rst_n)
      vld && bcast_mem && form == 2'd2 |-> op_y[k*ELEM_W +: ELEM_W] == src3[ELEM_W-1:0]);
  end

endmodule

// File: rtl/fma_ctx_delay.sv
module fma_ctx_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 3,
  localparam int CW   = $clog2(DEPTH + 2) + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_data,
  output logic         out_vld,
  output logic [W-1:0] out_data
);

  logic [W-1:0] st [DEPTH];
  logic         sv [DEPTH];
  logic [CW-1:0] inflight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        st[i] <= '0;
        sv[i] <= 1'b0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i == 0) begin
          st[i] <= in_data;
          sv[i] <= in_vld;
        end else begin
          st[i] <= st[i-1];
          sv[i] <= sv[i-1];
        end
      end
    end
  end

  assign out_vld  = sv[DEPTH-1];
  assign out_data = st[DEPTH-1];

  // Occupancy tracker used only to guard ordering
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else begin
      case ({in_vld, out_vld})
        2'b10:   inflight <= inflight + CW'(1);
        2'b01:   inflight <= inflight - CW'(1);
        default: inflight <= inflight;
      endcase
    end
  end

  // R10: nothing leaves that did not enter
  p_out_needs_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> inflight != '0);
  // R10: never more items in flight than stages
  p_depth_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= CW'(DEPTH));

endmodule

// File: rtl/fma_mask_merge.sv
module fma_mask_merge
  import fma_route_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int FLAG_W = 5,
  localparam int VW  = LANES * ELEM_W,
  localparam int FAW = LANES * FLAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld,
  input  logic [LANES-1:0]  wr,
  input  logic [LANES-1:0]  act,
  input  logic              zero,
  input  logic [VW-1:0]     dest,
  input  logic [VW-1:0]     res,
  input  logic [FAW-1:0]    flags,
  output logic [VW-1:0]     merged,
  output logic [FLAG_W-1:0] flag_or
);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign merged[k*ELEM_W +: ELEM_W] = merge_lane(wr[k], act[k], zero,
                                                   res[k*ELEM_W +: ELEM_W],
                                                   dest[k*ELEM_W +: ELEM_W]);
    // R4: lanes past the active length are cleared
    p_inactive_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      vld && !act[k] |-> merged[k*ELEM_W +: ELEM_W] == '0);
    // R5/R6: an unwritten active lane is either the old value or zero
    p_masked_keep_or_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      vld && act[k] && !wr[k] |-> merged[k*ELEM_W +: ELEM_W] == dest[k*ELEM_W +: ELEM_W] ||
                                  merged[k*ELEM_W +: ELEM_W] == '0);
  end

  always_comb begin
    flag_or = '0;
    for (int k = 0; k < LANES; k++) begin
      if (wr[k]) flag_or = flag_or | flags[k*FLAG_W +: FLAG_W];
    end
  end

  // R11: no written lane, no flags
  p_flags_need_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    vld && wr == '0 |-> flag_or == '0);

endmodule

// File: rtl/fma_route_merge.sv
module fma_route_merge
  import fma_route_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int FLAG_W = 5,
  parameter int LAT    = 3,
  localparam int VW    = LANES * ELEM_W,
  localparam int FAW   = LANES * FLAG_W,
  localparam int CTX_W = VW + 2 * LANES + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_form,
  input  logic [1:0]        in_vlen,
  input  logic [VW-1:0]     in_dest,
  input  logic [VW-1:0]     in_src2,
  input  logic [VW-1:0]     in_src3,
  input  logic [LANES-1:0]  in_mask,
  input  logic              in_mask_en,
  input  logic              in_zero_mode,
  input  logic              in_bcast,
  input  logic              in_src3_mem,
  input  logic              in_legacy,
  input  logic [RC_W-1:0]   in_embed_rc,
  input  logic [RC_W-1:0]   in_global_rc,
  output logic              lane_issue,
  output logic [VW-1:0]     lane_x,
  output logic [VW-1:0]     lane_y,
  output logic [VW-1:0]     lane_z,
  output logic [LANES-1:0]  lane_enable,
  output logic [RC_W-1:0]   lane_rc,
  input  logic [VW-1:0]     lane_res,
  input  logic [FAW-1:0]    lane_flags,
  output logic              out_valid,
  output logic [VW-1:0]     out_data,
  output logic [FLAG_W-1:0] out_flags
);

  // Stage 1: registered request
  logic              s1_v;
  logic [1:0]        s1_form, s1_vlen;
  logic [VW-1:0]     s1_dest, s1_src2, s1_src3;
  logic [LANES-1:0]  s1_mask;
  logic              s1_men, s1_zm, s1_bc, s1_mem, s1_leg;
  logic [RC_W-1:0]   s1_erc, s1_grc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_form <= '0;
      s1_vlen <= '0;
      s1_dest <= '0;
      s1_src2 <= '0;
      s1_src3 <= '0;
      s1_mask <= '0;
      s1_men  <= 1'b0;
      s1_zm   <= 1'b0;
      s1_bc   <= 1'b0;
      s1_mem  <= 1'b0;
      s1_leg  <= 1'b0;
      s1_erc  <= '0;
      s1_grc  <= '0;
    end else begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_form <= in_form;
        s1_vlen <= in_vlen;
        s1_dest <= in_dest;
        s1_src2 <= in_src2;
        s1_src3 <= in_src3;
        s1_mask <= in_mask;
        s1_men  <= in_mask_en;
        s1_zm   <= in_zero_mode;
        s1_bc   <= in_bcast;
        s1_mem  <= in_src3_mem;
        s1_leg  <= in_legacy;
        s1_erc  <= in_embed_rc;
        s1_grc  <= in_global_rc;
      end
    end
  end

  // Lane activity and write decisions
  logic [7:0]       act_cnt;
  logic [LANES-1:0] act_vec, wr_vec;
  logic             mask_used, zero_eff;

  assign act_cnt   = lane_count(s1_vlen, s1_leg);
  assign mask_used = s1_men & ~s1_leg;
  assign zero_eff  = s1_zm & mask_used;

  for (genvar k = 0; k < LANES; k++) begin : g_act
    assign act_vec[k] = (k < int'(act_cnt));
  end

  assign wr_vec = act_vec & (mask_used ? s1_mask : {LANES{1'b1}});

  fma_operand_route #(.LANES(LANES)) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .vld       (s1_v),
    .form      (s1_form),
    .bcast_mem (s1_bc & s1_mem),
    .dest      (s1_dest),
    .src2      (s1_src2),
    .src3      (s1_src3),
    .op_x      (lane_x),
    .op_y      (lane_y),
    .op_z      (lane_z)
  );

  assign lane_issue  = s1_v;
  assign lane_enable = wr_vec;
  assign lane_rc     = pick_rc(s1_vlen, s1_bc, s1_mem, s1_leg, s1_erc, s1_grc);

  // Context travelling beside the lanes
  logic             c_v;
  logic [CTX_W-1:0] c_data;
  logic [VW-1:0]    c_dest;
  logic [LANES-1:0] c_wr, c_act;
  logic             c_zero;

  fma_ctx_delay #(.W(CTX_W), .DEPTH(LAT)) u_ctx (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (s1_v),
    .in_data  ({s1_dest, wr_vec, act_vec, zero_eff}),
    .out_vld  (c_v),
    .out_data (c_data)
  );

  assign {c_dest, c_wr, c_act, c_zero} = c_data;

  logic [VW-1:0]     merged;
  logic [FLAG_W-1:0] flag_or;

  fma_mask_merge #(.LANES(LANES), .FLAG_W(FLAG_W)) u_merge (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld     (c_v),
    .wr      (c_wr),
    .act     (c_act),
    .zero    (c_zero),
    .dest    (c_dest),
    .res     (lane_res),
    .flags   (lane_flags),
    .merged  (merged),
    .flag_or (flag_or)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_flags <= '0;
    end else begin
      out_valid <= c_v;
      if (c_v) begin
        out_data  <= merged;
        out_flags <= flag_or;
      end
    end
  end

  // R8: the rounding mode is always one of the two candidates
  p_rc_candidate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v |-> lane_rc == s1_erc || lane_rc == s1_grc);
  // R9: legacy requests always use the global rounding mode
  p_legacy_rc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v && s1_leg |-> lane_rc == s1_grc);
  // R9: legacy requests never enable more than eight lanes
  p_legacy_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v && s1_leg |-> $countones(lane_enable) <= 8);
  // R10: issue follows an accepted request by one edge
  p_issue_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lane_issue |-> $past(in_valid));

endmodule

// File: tb/tb_fma_route_merge.sv
module tb_fma_route_merge;

  localparam int CLK_PERIOD = 10;
  localparam int LANES = 16;
  localparam int LAT   = 3;
  localparam int VW    = LANES * 32;
  localparam int FAW   = LANES * 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic             in_valid = 1'b0;
  logic [1:0]       in_form = '0, in_vlen = '0;
  logic [VW-1:0]    in_dest = '0, in_src2 = '0, in_src3 = '0;
  logic [LANES-1:0] in_mask = '0;
  logic             in_mask_en = 1'b0, in_zero_mode = 1'b0, in_bcast = 1'b0;
  logic             in_src3_mem = 1'b0, in_legacy = 1'b0;
  logic [1:0]       in_embed_rc = '0, in_global_rc = '0;
  logic             lane_issue, out_valid;
  logic [VW-1:0]    lane_x, lane_y, lane_z, lane_res, out_data;
  logic [LANES-1:0] lane_enable;
  logic [1:0]       lane_rc;
  logic [FAW-1:0]   lane_flags;
  logic [4:0]       out_flags;

  fma_route_merge #(.LANES(LANES), .FLAG_W(5), .LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_form(in_form), .in_vlen(in_vlen),
    .in_dest(in_dest), .in_src2(in_src2), .in_src3(in_src3), .in_mask(in_mask),
    .in_mask_en(in_mask_en), .in_zero_mode(in_zero_mode), .in_bcast(in_bcast),
    .in_src3_mem(in_src3_mem), .in_legacy(in_legacy), .in_embed_rc(in_embed_rc),
    .in_global_rc(in_global_rc), .lane_issue(lane_issue), .lane_x(lane_x), .lane_y(lane_y),
    .lane_z(lane_z), .lane_enable(lane_enable), .lane_rc(lane_rc), .lane_res(lane_res),
    .lane_flags(lane_flags), .out_valid(out_valid), .out_data(out_data), .out_flags(out_flags)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  // Stand-in arithmetic lanes: non-symmetric so operand swaps are visible
  function automatic logic [36:0] lane_fn(logic [31:0] x, logic [31:0] y, logic [31:0] z);
    logic [31:0] r;
    r = x + 32'd3 * y + 32'd5 * z;
    return {(x[4:0] ^ y[4:0] ^ z[4:0]), r};
  endfunction

  logic [VW-1:0]  lm_res [LAT];
  logic [FAW-1:0] lm_flg [LAT];
  always @(posedge clk) begin
    for (int i = LAT - 1; i > 0; i--) begin
      lm_res[i] <= lm_res[i-1];
      lm_flg[i] <= lm_flg[i-1];
    end
    for (int k = 0; k < LANES; k++) begin
      logic [36:0] v;
      v = lane_fn(lane_x[k*32 +: 32], lane_y[k*32 +: 32], lane_z[k*32 +: 32]);
      lm_res[0][k*32 +: 32] <= lane_issue ? v[31:0] : 32'h0;
      lm_flg[0][k*5 +: 5]   <= lane_issue ? v[36:32] : 5'h0;
    end
  end
  assign lane_res   = lm_res[LAT-1];
  assign lane_flags = lm_flg[LAT-1];

  // Scoreboard queues
  logic [VW-1:0] q_data [$];
  logic [4:0]    q_flags [$];
  int            q_cyc [$];
  string         q_tag [$];
  logic [1:0]    q_rc [$];
  string         q_rctag [$];

  task automatic check(bit ok, string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] rvec();
    logic [VW-1:0] v;
    for (int k = 0; k < LANES; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic send(input logic [1:0] form, input logic [1:0] vlen, input logic [VW-1:0] d,
                      input logic [VW-1:0] s2, input logic [VW-1:0] s3,
                      input logic [LANES-1:0] mask, input bit men, input bit zm,
                      input bit bc, input bit mem, input bit leg,
                      input logic [1:0] erc, input logic [1:0] grc, input string tag);
    logic [VW-1:0] ed;
    logic [4:0]    ef;
    int            n;
    bit            um;
    @(negedge clk);
    in_valid = 1'b1; in_form = form; in_vlen = vlen; in_dest = d; in_src2 = s2; in_src3 = s3;
    in_mask = mask; in_mask_en = men; in_zero_mode = zm; in_bcast = bc; in_src3_mem = mem;
    in_legacy = leg; in_embed_rc = erc; in_global_rc = grc;
    n  = (vlen == 2'd0) ? 4 : (vlen == 2'd1) ? 8 : (leg ? 8 : 16);
    um = men && !leg;
    ed = '0; ef = '0;
    for (int j = 0; j < LANES; j++) begin
      logic [31:0] dj, s2j, s3j, x, y, z;
      logic [36:0] v;
      dj  = d[j*32 +: 32];
      s2j = s2[j*32 +: 32];
      s3j = (bc && mem) ? s3[31:0] : s3[j*32 +: 32];
      case (form)
        2'd1:    begin x = s2j; y = dj;  z = s3j; end
        2'd2:    begin x = s2j; y = s3j; z = dj;  end
        default: begin x = dj;  y = s3j; z = s2j; end
      endcase
      v = lane_fn(x, y, z);
      if (j < n) begin
        if (!um || mask[j]) begin
          ed[j*32 +: 32] = v[31:0];
          ef = ef | v[36:32];
        end else if (zm) ed[j*32 +: 32] = 32'h0;
        else ed[j*32 +: 32] = dj;
      end
    end
    q_data.push_back(ed);
    q_flags.push_back(ef);
    q_cyc.push_back(cyc + LAT + 2);
    q_tag.push_back(tag);
    q_rc.push_back((vlen >= 2'd2 && bc && !mem && !leg) ? erc : grc);
    q_rctag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (lane_issue) begin
        if (q_rc.size() == 0) check(1'b0, "R10 unexpected issue", '0, '0);
        else begin
          logic [1:0] erc;
          string t;
          erc = q_rc.pop_front();
          t   = q_rctag.pop_front();
          check(lane_rc == erc, {"R8 rounding ", t}, VW'(lane_rc), VW'(erc));
        end
      end
      if (out_valid) begin
        if (q_data.size() == 0) check(1'b0, "R10 unexpected output", out_data, '0);
        else begin
          logic [VW-1:0] ed;
          logic [4:0]    ef;
          int            ec;
          string         t;
          ed = q_data.pop_front();
          ef = q_flags.pop_front();
          ec = q_cyc.pop_front();
          t  = q_tag.pop_front();
          check(out_data == ed, {t, " data"}, out_data, ed);
          check(out_flags == ef, {"R11 flags ", t}, VW'(out_flags), VW'(ef));
          check(cyc == ec, {"R10 latency ", t}, VW'(cyc), VW'(ec));
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [VW-1:0] a, b, c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && lane_issue == 1'b0, "R10 reset valid",
          VW'({out_valid, lane_issue}), '0);
    check(out_data == '0, "R10 reset data", out_data, '0);

    a = rvec(); b = rvec(); c = rvec();
    send(2'd0, 2'd2, a, b, c, '0, 0, 0, 0, 0, 0, 2'd1, 2'd2, "R1 form0 512");
    idle();
    send(2'd1, 2'd2, a, b, c, '0, 0, 0, 0, 0, 0, 2'd1, 2'd2, "R2 form1 512");
    idle();
    send(2'd2, 2'd2, a, b, c, '0, 0, 0, 0, 0, 0, 2'd1, 2'd2, "R3 form2 512");
    idle();
    send(2'd2, 2'd0, rvec(), rvec(), rvec(), '0, 0, 0, 0, 0, 0, 2'd0, 2'd3, "R4 len128");
    idle();
    send(2'd0, 2'd1, rvec(), rvec(), rvec(), '0, 0, 0, 0, 0, 0, 2'd0, 2'd3, "R4 len256");
    idle();
    send(2'd1, 2'd2, rvec(), rvec(), rvec(), 16'hA5C3, 1, 0, 0, 0, 0, 2'd0, 2'd1, "R5 merge mask");
    idle();
    send(2'd2, 2'd2, rvec(), rvec(), rvec(), 16'h3C96, 1, 1, 0, 0, 0, 2'd0, 2'd1, "R6 zero mask");
    idle();
    send(2'd0, 2'd2, rvec(), rvec(), rvec(), 16'h0000, 1, 1, 0, 0, 0, 2'd0, 2'd1, "R11 all masked");
    idle();
    send(2'd2, 2'd2, rvec(), rvec(), rvec(), '0, 0, 0, 1, 1, 0, 2'd3, 2'd0, "R7 bcast mem");
    idle();
    send(2'd0, 2'd2, rvec(), rvec(), rvec(), '0, 0, 0, 1, 1, 0, 2'd3, 2'd0, "R7 bcast mem form0");
    idle();
    send(2'd1, 2'd2, rvec(), rvec(), rvec(), '0, 0, 0, 1, 0, 0, 2'd3, 2'd0, "R8 embed rc 512");
    idle();
    send(2'd1, 2'd1, rvec(), rvec(), rvec(), '0, 0, 0, 1, 0, 0, 2'd3, 2'd0, "R8 global rc 256");
    idle();
    send(2'd0, 2'd2, rvec(), rvec(), rvec(), 16'h00F0, 1, 1, 1, 0, 1, 2'd3, 2'd1, "R9 legacy");
    idle();
    // R10: back-to-back burst
    for (int i = 0; i < 6; i++) begin
      send(2'(i % 3), 2'(i % 3), rvec(), rvec(), rvec(), 16'($urandom), 1'(i & 1), 1'(i >> 1),
           1'(i == 4), 1'(i == 4), 1'b0, 2'd2, 2'd1, "R10 burst");
    end
    idle();
    for (int i = 0; i < 40 && q_data.size() != 0; i++) @(negedge clk);
    check(q_data.size() == 0, "R10 drain", VW'(q_data.size()), '0);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule